// File: doc/BRIEF.md
# Multi-Channel Programmable Interval Timer

This block holds several independent interval timers behind one small register bus. Each channel keeps a reload value written by software and a counter that moves one step for every pulse of a shared reference enable. When the counter reaches its terminal value, the channel sets a sticky pending flag. That flag drives the channel's interrupt line when the interrupt is enabled.

Software sets a channel's reload value and then starts it through its control register. The channel can be set to fire once or to run repeatedly. It can count down from the reload value to zero, or up from zero to the reload value. The interrupt enable only masks the output. The counter and the pending flag keep working when the interrupt is disabled. A new reload value written while a channel runs is picked up at the next reload, so the interval that is already in progress is never cut short.

Top module: `tmr_block`

## Requirements
- R1: After reset every register of every channel reads zero and all interrupt lines are low.
- R2: The bus address is {channel index, 2-bit select}. Select 0 is control, with bit0 run, bit1 auto-reload, bit2 count up and bit3 interrupt enable. Select 1 is the reload value. Select 2 is the live count and is read-only. Select 3 is status, with bit0 the pending flag. Read data is combinational from the address, and writes take effect at the clock edge.
- R3: A control write that sets run while the channel is stopped loads the counter. It loads the reload value when counting down and zero when counting up. A ticked cycle that carries a control write to the same channel does not count.
- R4: Counting down, each tick lowers the count by one. The tick that finds the count at 1 or 0 is the expiry tick, so one interval is max(reload,1) ticks.
- R5: Counting up, each tick raises the count by one. The tick where count+1 is at or above the active limit is the expiry tick, so one interval is max(reload,1) ticks.
- R6: In auto-reload mode, the expiry tick reloads the counter in that same cycle (reload value when counting down, zero when counting up) and the channel keeps running.
- R7: In one-shot mode, the expiry tick leaves the count at its terminal value (zero when counting down, the limit when counting up) and clears the run bit.
- R8: A reload-value write while the channel runs does not change the live count or the active limit until the next start or reload.
- R9: The pending flag is set by expiry and stays set until a status write with bit0=1. A status write with bit0=0 does nothing. When expiry and clear fall in the same cycle, the flag ends up set.
- R10: A channel's interrupt line is its pending flag ANDed with its interrupt-enable bit. A channel with the interrupt disabled still counts and still sets pending.
- R11: Channels are independent. Writes reach only the addressed channel. An address whose channel index has no channel reads zero and its writes are dropped. Writes to the count select are dropped.
- R12: Ticks are ignored while a channel is stopped, and its count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference enable; one count step per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | CH_W+2 (4) | {channel index, register select} |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Combinational read data for bus_addr |
| irq | output | NUM_CH (3) | Per-channel interrupt lines |

## Verification
A wrong count, limit or mode bit inside a channel shows at the count read-back on the very next cycle. It also moves the expiry tick, so the pending flag and the interrupt line change one or more ticks early or late, or never change. A reload that takes the new value too early, or a one-shot that fails to stop, shows as a wrong count or a wrong run bit within one interval of the fault. Every cycle, a cycle-level model in the bench compares the read data for the driven address and all interrupt lines. Directed sequences pin the exact expiry ticks for each mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // control word layout: bit0 run, bit1 auto-reload, bit2 count up, bit3 irq enable
    typedef struct packed {
        logic irq_en;
        logic dir_up;
        logic auto_rl;
        logic run;
    } tmr_ctrl_t;

    localparam int CTRL_BITS = $bits(tmr_ctrl_t);

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_HOLD  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_STAT  = 2'd3
    } tmr_sel_e;

    function automatic int unsigned chan_idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int CH_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic [CH_W+1:0]               bus_addr,
    input  tmr_ctrl_t [NUM_CH-1:0]        ctrl_rd,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  hold_rd,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  count_rd,
    input  logic [NUM_CH-1:0]             pend_rd,
    output logic [NUM_CH-1:0]             wr_ctrl,
    output logic [NUM_CH-1:0]             wr_hold,
    output logic [NUM_CH-1:0]             wr_stat,
    output logic [CNT_W-1:0]              bus_rdata
);

    logic [CH_W-1:0] ch_idx;
    tmr_sel_e        sel;

    assign ch_idx = bus_addr[CH_W+1:2];
    assign sel    = tmr_sel_e'(bus_addr[1:0]);

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr_ctrl[c] = bus_wr && (ch_idx == CH_W'(c)) && (sel == SEL_CTRL);
            wr_hold[c] = bus_wr && (ch_idx == CH_W'(c)) && (sel == SEL_HOLD);
            wr_stat[c] = bus_wr && (ch_idx == CH_W'(c)) && (sel == SEL_STAT);
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_W'(c)) begin
                unique case (sel)
                    SEL_CTRL:  bus_rdata = CNT_W'(ctrl_rd[c]);
                    SEL_HOLD:  bus_rdata = hold_rd[c];
                    SEL_COUNT: bus_rdata = count_rd[c];
                    SEL_STAT:  bus_rdata = CNT_W'(pend_rd[c]);
                endcase
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_ctrl, wr_hold, wr_stat})); // R11

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_ctrl,
    input  logic             wr_hold,
    input  logic             wr_stat,
    input  logic [CNT_W-1:0] wdata,
    output tmr_ctrl_t        ctrl_q,
    output logic [CNT_W-1:0] hold_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pend_q,
    output logic             irq
);

    logic [CNT_W-1:0] lim_q;
    logic             term;
    logic             step;
    logic             expire;
    tmr_ctrl_t        ctrl_new;

    assign ctrl_new = tmr_ctrl_t'(wdata[CTRL_BITS-1:0]);

    always_comb begin
        if (ctrl_q.dir_up)
            term = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, lim_q};
        else
            term = cnt_q <= CNT_W'(1);
    end

    assign step   = tick && ctrl_q.run && !wr_ctrl;
    assign expire = step && term;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            hold_q <= '0;
            cnt_q  <= '0;
            lim_q  <= '0;
        end else begin
            if (wr_hold)
                hold_q <= wdata;
            if (wr_ctrl) begin
                ctrl_q <= ctrl_new;
                if (ctrl_new.run && !ctrl_q.run) begin
                    cnt_q <= ctrl_new.dir_up ? '0 : hold_q;
                    lim_q <= hold_q;
                end
            end else if (step) begin
                if (term) begin
                    if (ctrl_q.auto_rl) begin
                        cnt_q <= ctrl_q.dir_up ? '0 : hold_q;
                        lim_q <= hold_q;
                    end else begin
                        cnt_q      <= ctrl_q.dir_up ? lim_q : '0;
                        ctrl_q.run <= 1'b0;
                    end
                end else begin
                    cnt_q <= ctrl_q.dir_up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (expire)
            pend_q <= 1'b1;
        else if (wr_stat && wdata[0])
            pend_q <= 1'b0;
    end

    assign irq = pend_q && ctrl_q.irq_en;

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
        expire && !ctrl_q.auto_rl |=> !ctrl_q.run); // R7

    AST_RELOAD_DOWN: assert property (@(posedge clk) disable iff (rst)
        expire && ctrl_q.auto_rl && !ctrl_q.dir_up |=> cnt_q == $past(hold_q)); // R6

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        pend_q && !wr_stat |=> pend_q); // R9

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run && !wr_ctrl |=> $stable(cnt_q)); // R12

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !term && !ctrl_q.dir_up |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !term && ctrl_q.dir_up |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R5

endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter  int NUM_CH = 3,
    parameter  int CNT_W  = 32,
    localparam int CH_W   = chan_idx_width(NUM_CH),
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    tmr_ctrl_t [NUM_CH-1:0]        ctrl_rd;
    logic [NUM_CH-1:0][CNT_W-1:0]  hold_rd;
    logic [NUM_CH-1:0][CNT_W-1:0]  count_rd;
    logic [NUM_CH-1:0]             pend_rd;
    logic [NUM_CH-1:0]             wr_ctrl;
    logic [NUM_CH-1:0]             wr_hold;
    logic [NUM_CH-1:0]             wr_stat;

    tmr_decode #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .CH_W   (CH_W)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ctrl_rd   (ctrl_rd),
        .hold_rd   (hold_rd),
        .count_rd  (count_rd),
        .pend_rd   (pend_rd),
        .wr_ctrl   (wr_ctrl),
        .wr_hold   (wr_hold),
        .wr_stat   (wr_stat),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        tmr_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wr_ctrl (wr_ctrl[g]),
            .wr_hold (wr_hold[g]),
            .wr_stat (wr_stat[g]),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_rd[g]),
            .hold_q  (hold_rd[g]),
            .cnt_q   (count_rd[g]),
            .pend_q  (pend_rd[g]),
            .irq     (irq[g])
        );
    end

    AST_IRQ_AFTER_RESET: assert property (@(posedge clk)
        rst |=> irq == '0); // R1

endmodule

// File: tb/tmr_block_bench.sv
module tmr_block_bench;

    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    always #2 clk = ~clk;

    tmr_block u_tmr_block (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] last_rd;
    logic [2:0]  last_irq;

    // reference model state
    logic        m_run [NCH];
    logic        m_rep [NCH];
    logic        m_up  [NCH];
    logic        m_ien [NCH];
    logic        m_pnd [NCH];
    logic [31:0] m_hold[NCH];
    logic [31:0] m_cnt [NCH];
    logic [31:0] m_lim [NCH];

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        int c = int'(a[3:2]);
        if (c >= NCH) return 32'h0;
        case (a[1:0])
            2'd0: return {28'h0, m_ien[c], m_up[c], m_rep[c], m_run[c]};
            2'd1: return m_hold[c];
            2'd2: return m_cnt[c];
            default: return {31'h0, m_pnd[c]};
        endcase
    endfunction

    function automatic logic [2:0] model_irq();
        logic [2:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_pnd[c] & m_ien[c];
        return v;
    endfunction

    task automatic model_step(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                              input logic tk);
        for (int c = 0; c < NCH; c++) begin
            logic hit = wr && (int'(a[3:2]) == c);
            logic wc  = hit && (a[1:0] == 2'd0);
            logic wh  = hit && (a[1:0] == 2'd1);
            logic ws  = hit && (a[1:0] == 2'd3);
            logic term;
            logic exp_now;
            logic [31:0] old_hold = m_hold[c];
            if (m_up[c]) term = ({1'b0, m_cnt[c]} + 33'd1) >= {1'b0, m_lim[c]};
            else         term = m_cnt[c] <= 32'd1;
            exp_now = tk && m_run[c] && !wc && term;
            if (wh) m_hold[c] = wd;
            if (wc) begin
                if (wd[0] && !m_run[c]) begin
                    m_cnt[c] = wd[2] ? 32'h0 : old_hold;
                    m_lim[c] = old_hold;
                end
                m_run[c] = wd[0]; m_rep[c] = wd[1]; m_up[c] = wd[2]; m_ien[c] = wd[3];
            end else if (tk && m_run[c]) begin
                if (term) begin
                    if (m_rep[c]) begin
                        m_cnt[c] = m_up[c] ? 32'h0 : old_hold;
                        m_lim[c] = old_hold;
                    end else begin
                        m_cnt[c] = m_up[c] ? m_lim[c] : 32'h0;
                        m_run[c] = 1'b0;
                    end
                end else begin
                    m_cnt[c] = m_up[c] ? m_cnt[c] + 1 : m_cnt[c] - 1;
                end
            end
            if (exp_now) m_pnd[c] = 1'b1;
            else if (ws && wd[0]) m_pnd[c] = 1'b0;
        end
    endtask

    task automatic cycle(input logic wr, input logic [3:0] a, input logic [31:0] wd,
                         input logic tk);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = wd; tick = tk;
        #1;
        last_rd  = bus_rdata;
        last_irq = irq;
        chk(bus_rdata, model_read(a), "R2 model readback");
        chk({29'h0, irq}, {29'h0, model_irq()}, "R10 model irq");
        @(posedge clk);
        model_step(wr, a, wd, tk);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        cycle(1'b0, a, 32'h0, 1'b0);
        chk(last_rd, exp, tag);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 4'd0, 32'h0, 1'b1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < NCH; c++) begin
            m_run[c] = 0; m_rep[c] = 0; m_up[c] = 0; m_ien[c] = 0; m_pnd[c] = 0;
            m_hold[c] = 0; m_cnt[c] = 0; m_lim[c] = 0;
        end
        rst = 1'b1; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R1 reset register");
        chk({29'h0, last_irq}, 32'h0, "R1 reset irq");

        // ch0 down, one-shot, irq enabled, reload 3
        cycle(1'b1, 4'd1, 32'd3, 1'b0);
        cycle(1'b1, 4'd0, 32'h9, 1'b0);
        rd(4'd2, 32'd3, "R3 start loads reload value");
        ticks(2);
        rd(4'd2, 32'd1, "R4 down count");
        chk({29'h0, last_irq}, 32'h0, "R4 no early expiry");
        ticks(1);
        rd(4'd2, 32'd0, "R4 expiry at zero");
        chk({29'h0, last_irq}, 32'h1, "R10 irq raised");
        rd(4'd0, 32'h8, "R7 one-shot clears run");
        ticks(2);
        rd(4'd2, 32'd0, "R12 stopped counter holds");

        // R9 sticky pending
        cycle(1'b1, 4'd3, 32'h0, 1'b0);
        rd(4'd3, 32'h1, "R9 zero write keeps pending");
        cycle(1'b1, 4'd3, 32'h1, 1'b0);
        rd(4'd3, 32'h0, "R9 one clears pending");
        chk({29'h0, last_irq}, 32'h0, "R10 irq drops with pending");

        // ch1 up, repeat, irq disabled, reload 4
        cycle(1'b1, 4'd5, 32'd4, 1'b0);
        cycle(1'b1, 4'd4, 32'h7, 1'b0);
        rd(4'd6, 32'd0, "R3 up start at zero");
        ticks(3);
        rd(4'd6, 32'd3, "R5 up count");
        ticks(1);
        rd(4'd6, 32'd0, "R6 up reload at limit");
        rd(4'd7, 32'h1, "R10 pending without enable");
        chk({29'h0, last_irq}, 32'h0, "R10 masked irq");

        // ch2 down, repeat, reload written while running
        cycle(1'b1, 4'd9, 32'd5, 1'b0);
        cycle(1'b1, 4'd8, 32'h3, 1'b0);
        ticks(1);
        rd(4'd10, 32'd4, "R4 first step");
        cycle(1'b1, 4'd9, 32'd2, 1'b0);
        rd(4'd10, 32'd4, "R8 reload write leaves count");
        ticks(3);
        rd(4'd10, 32'd1, "R8 old interval continues");
        ticks(1);
        rd(4'd10, 32'd2, "R8 new value at reload");
        rd(4'd11, 32'h1, "R6 repeat expiry sets pending");

        // R11 isolation and dropped writes
        cycle(1'b1, 4'd12, 32'hFF, 1'b0);
        rd(4'd12, 32'h0, "R11 unmapped channel");
        cycle(1'b1, 4'd2, 32'h55, 1'b0);
        rd(4'd2, 32'h0, "R11 count write dropped");
        rd(4'd0, 32'h8, "R11 ch0 control intact");

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic        w  = ($urandom_range(0, 3) == 0);
            logic [3:0]  a  = 4'($urandom_range(0, 15));
            logic [31:0] wd;
            logic        tk = $urandom_range(0, 1) == 1;
            case (a[1:0])
                2'd0:    wd = 32'($urandom_range(0, 15));
                2'd1:    wd = 32'($urandom_range(0, 6));
                default: wd = 32'($urandom_range(0, 1));
            endcase
            cycle(w, a, wd, tk);
        end

        summary();
        $finish;
    end

endmodule